// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a bank of general-purpose pins controlled through a small word-wide register bus. Each pin can be switched between driving a level (output) and sampling an external level (input). Input levels are brought into the clock domain through a two-stage synchronizer and stored in the data register. A change on an input pin records an interrupt event. Each pin selects whether a rising or a falling level records an event, or only a falling level does.

Software enables events bit by bit with a mask and clears them by writing ones. A single level-sensitive interrupt line stays high while any unmasked event is pending. Pin numbering runs from the most significant register bit downward: pin n lives at register bit (PINS-1-n). Open-drain selection is held as plain storage for the pad logic outside this block.

The bus has no back-pressure. A strobe is accepted in the cycle it is seen, so there is no valid/ready pair. A write takes effect at the clock edge that samples the strobe. Read data appears on `bus_rdata` in the following cycle.

Top module: `edge_gpio`

## Requirements
- R1: After reset, all six registers read as zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: The registers sit at these byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, control 0x14. The direction, open-drain, mask and control registers read back exactly what was last written. Read data is presented the cycle after the read strobe and is zero in any cycle that does not follow a read. Any other offset reads as zero, and a write to it changes no register.
- R3: An access is a word access only when `bus_size` is 2'b10 and `bus_addr[1:0]` is 2'b00. Any other access is ignored on write and returns zero on read (`bus_size` 2'b00 is a byte and 2'b01 is a halfword).
- R4: Pin n maps to register bit (PINS-1-n). `pin_oe[n]` equals direction bit (PINS-1-n), and `pin_out[n]` equals data bit (PINS-1-n).
- R5: On a pin whose direction bit is 1 (output), a data-register write sets the bit. The external input on that pin changes neither its data bit nor its event bit.
- R6: On a pin whose direction bit is 0 (input), the data bit follows the synchronized pin level, and data-register writes leave that bit unchanged. Take a level driven before clock edge k. It reaches the data bit, and any event it causes, at edge k+2. It is therefore visible on `irq` after edge k+2.
- R7: With control bit 0, any difference between the synchronized level and the stored data bit of an input pin sets its event bit.
- R8: With control bit 1, only a fall (stored data bit 1, synchronized level 0) sets the event bit; a rise does not.
- R9: A write to the event register clears every bit where the written word has a 1 and leaves the other bits unchanged.
- R10: If an event set and a software clear hit the same bit at the same edge, the bit ends up set.
- R11: `irq` is high exactly when some bit is 1 in both the event register and the mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, valid the cycle after a read strobe |
| pin_in | input | PINS | External pin levels, pin n on bit n |
| pin_out | output | PINS | Driven pin levels, pin n on bit n |
| pin_oe | output | PINS | Output enable per pin, pin n on bit n |
| irq | output | 1 | Interrupt, high while any masked event is pending |

## Verification
A corrupt direction or data bit shows up directly on `pin_oe` or `pin_out` in the cycle after the faulty edge. A wrong event or mask bit shows on `irq` at the same time. An input-path fault shows on a register read, or on `irq`, two edges after the pin moves. A lost or spurious event persists until software clears it, so a read of the event register after each stimulus exposes it. The set-versus-clear collision needs the clear write to land on exactly edge k+2 after a pin change. A write one cycle later must show the opposite outcome.

// File: rtl/egpio_pkg.sv
package egpio_pkg;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  localparam int unsigned OFS_DIR = 'h00;
  localparam int unsigned OFS_ODR = 'h04;
  localparam int unsigned OFS_DAT = 'h08;
  localparam int unsigned OFS_EVT = 'h0C;
  localparam int unsigned OFS_MSK = 'h10;
  localparam int unsigned OFS_CTL = 'h14;

  localparam int unsigned NREGS = 6;
  localparam int unsigned IX_DIR = 0;
  localparam int unsigned IX_ODR = 1;
  localparam int unsigned IX_DAT = 2;
  localparam int unsigned IX_EVT = 3;
  localparam int unsigned IX_MSK = 4;
  localparam int unsigned IX_CTL = 5;

  typedef enum logic [2:0] {
    SEL_DIR, SEL_ODR, SEL_DAT, SEL_EVT, SEL_MSK, SEL_CTL, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/egpio_sync.sv
module egpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/egpio_decode.sv
module egpio_decode
  import egpio_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [1:0]       bus_size,
  output logic [NREGS-1:0] wr_en,
  output logic             rd_go,
  output reg_sel_e         rd_sel
);
  logic     word_ok;
  reg_sel_e hit;

  assign word_ok = (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    hit = SEL_NONE;
    if      (bus_addr == AW'(OFS_DIR)) hit = SEL_DIR;
    else if (bus_addr == AW'(OFS_ODR)) hit = SEL_ODR;
    else if (bus_addr == AW'(OFS_DAT)) hit = SEL_DAT;
    else if (bus_addr == AW'(OFS_EVT)) hit = SEL_EVT;
    else if (bus_addr == AW'(OFS_MSK)) hit = SEL_MSK;
    else if (bus_addr == AW'(OFS_CTL)) hit = SEL_CTL;
  end

  always_comb begin
    wr_en = '0;
    if (bus_sel && bus_we && word_ok) begin
      unique case (hit)
        SEL_DIR: wr_en[IX_DIR] = 1'b1;
        SEL_ODR: wr_en[IX_ODR] = 1'b1;
        SEL_DAT: wr_en[IX_DAT] = 1'b1;
        SEL_EVT: wr_en[IX_EVT] = 1'b1;
        SEL_MSK: wr_en[IX_MSK] = 1'b1;
        SEL_CTL: wr_en[IX_CTL] = 1'b1;
        default: wr_en = '0;
      endcase
    end
  end

  assign rd_go  = bus_sel && !bus_we;
  assign rd_sel = word_ok ? hit : SEL_NONE;
endmodule

// File: rtl/egpio_edge.sv
module egpio_edge #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] ctl_q,
  output logic [W-1:0] set_evt
);
  for (genvar b = 0; b < int'(W); b++) begin : g_bit
    logic moved;
    logic fell;
    assign moved      = lvl[b] ^ data_q[b];
    assign fell       = data_q[b] & ~lvl[b];
    assign set_evt[b] = ~dir_q[b] & (ctl_q[b] ? fell : moved);
  end
endmodule

// File: rtl/edge_gpio.sv
module edge_gpio
  import egpio_pkg::*;
#(
  parameter int unsigned PINS      = 32,
  parameter int unsigned AW        = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [1:0]      bus_size,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  localparam int unsigned TOP = PINS - 1;

  logic [PINS-1:0]  dir_q, odr_q, data_q, evt_q, mask_q, ctl_q;
  logic [PINS-1:0]  pin_reg_order, lvl_sync, set_evt;
  logic [PINS-1:0]  data_d, evt_d, clr_bits, rd_mux;
  logic [NREGS-1:0] wr_en;
  logic             rd_go;
  reg_sel_e         rd_sel;

  // pin n <-> register bit TOP-n
  for (genvar n = 0; n < int'(PINS); n++) begin : g_map
    assign pin_reg_order[TOP-n] = pin_in[n];
    assign pin_oe[n]            = dir_q[TOP-n];
    assign pin_out[n]           = data_q[TOP-n];
  end

  egpio_sync #(.W(PINS), .STAGES(SYNC_STGS)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_reg_order),
    .dout (lvl_sync)
  );

  egpio_decode #(.AW(AW)) i_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .bus_size(bus_size),
    .wr_en   (wr_en),
    .rd_go   (rd_go),
    .rd_sel  (rd_sel)
  );

  egpio_edge #(.W(PINS)) i_edge (
    .lvl    (lvl_sync),
    .data_q (data_q),
    .dir_q  (dir_q),
    .ctl_q  (ctl_q),
    .set_evt(set_evt)
  );

  // outputs take written data; inputs track the synchronized level
  always_comb begin
    for (int b = 0; b < int'(PINS); b++) begin
      if (dir_q[b]) data_d[b] = wr_en[IX_DAT] ? bus_wdata[b] : data_q[b];
      else          data_d[b] = lvl_sync[b];
    end
  end

  // write-one-to-clear, a same-edge set takes priority
  assign clr_bits = wr_en[IX_EVT] ? bus_wdata : '0;
  assign evt_d    = (evt_q & ~clr_bits) | set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      odr_q  <= '0;
      data_q <= '0;
      evt_q  <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_en[IX_DIR]) dir_q  <= bus_wdata;
      if (wr_en[IX_ODR]) odr_q  <= bus_wdata;
      if (wr_en[IX_MSK]) mask_q <= bus_wdata;
      if (wr_en[IX_CTL]) ctl_q  <= bus_wdata;
      data_q <= data_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_DIR: rd_mux = dir_q;
      SEL_ODR: rd_mux = odr_q;
      SEL_DAT: rd_mux = data_q;
      SEL_EVT: rd_mux = evt_q;
      SEL_MSK: rd_mux = mask_q;
      SEL_CTL: rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/edge_gpio_chk.sv
module edge_gpio_chk #(
  parameter int unsigned PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] dir_q,
  input logic [PINS-1:0] ctl_q,
  input logic [PINS-1:0] data_q,
  input logic [PINS-1:0] evt_q,
  input logic [PINS-1:0] set_evt,
  input logic            wr_data_en,
  input logic            wr_evt_en,
  input logic            rd_go,
  input logic [PINS-1:0] wdata,
  input logic [PINS-1:0] rdata
);
  // R2: read data is zero unless the previous cycle carried a read strobe
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_go) |-> (rdata == '0));

  // R5: new events only appear on pins that were inputs
  p_evt_input_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & $past(dir_q)) == '0));

  // R5: output data bits hold unless the data register is written
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_data_en) |-> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

  // R7, R10: an any-change input whose stored level moved must hold an event
  p_change_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((data_q ^ $past(data_q)) & ~$past(dir_q) & ~$past(ctl_q) & ~evt_q) == '0));

  // R8: falling-only pins gain events only on a fall
  p_fall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & $past(ctl_q) & ~($past(data_q) & ~data_q)) == '0));

  // R9: written ones clear bits that had no simultaneous set
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_evt_en) |-> ((evt_q & $past(wdata) & ~$past(set_evt)) == '0));
endmodule

bind edge_gpio edge_gpio_chk #(.PINS(PINS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_q     (dir_q),
  .ctl_q     (ctl_q),
  .data_q    (data_q),
  .evt_q     (evt_q),
  .set_evt   (set_evt),
  .wr_data_en(wr_en[egpio_pkg::IX_DAT]),
  .wr_evt_en (wr_en[egpio_pkg::IX_EVT]),
  .rd_go     (rd_go),
  .wdata     (bus_wdata),
  .rdata     (bus_rdata)
);

// File: tb/test_edge_gpio.sv
module test_edge_gpio;
  localparam int CLK_P = 10;
  localparam int PINS  = 32;
  localparam int AW    = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [1:0]      bus_size = 2'b10;
  logic [PINS-1:0] bus_wdata = '0, bus_rdata;
  logic [PINS-1:0] pin_in = '0, pin_out, pin_oe;
  logic            irq;

  edge_gpio #(.PINS(PINS), .AW(AW)) i_edge_gpio (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model, register bit order
  logic [31:0] m_dir = '0, m_odr = '0, m_dat = '0, m_evt = '0, m_msk = '0, m_ctl = '0;
  logic [31:0] m_lvl = '0;

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction

  function automatic logic [31:0] evt_rule(input logic [31:0] old, lvl, dir, ctl);
    return ~dir & ((~ctl & (old ^ lvl)) | (ctl & old & ~lvl));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [31:0] p);
    pin_in = p;
    m_lvl  = rev(p);
  endtask

  task automatic model_inputs();
    m_evt = m_evt | evt_rule(m_dat, m_lvl, m_dir, m_ctl);
    m_dat = (m_dat & m_dir) | (m_lvl & ~m_dir);
  endtask

  task automatic settle();
    idle(4);
    model_inputs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0; bus_size = 2'b10;
    if (sz == 2'b10 && a[1:0] == 2'b00) begin
      case (a)
        8'h00: m_dir = d;
        8'h04: m_odr = d;
        8'h08: m_dat = (m_dat & ~m_dir) | (d & m_dir);
        8'h0C: m_evt = m_evt & ~d;
        8'h10: m_msk = d;
        8'h14: m_ctl = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'b10);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0; bus_size = 2'b10;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(8'h00, v); chk({tag, " R2 dir"}, v, m_dir);
    rd(8'h04, v); chk({tag, " R2 odr"}, v, m_odr);
    rd(8'h08, v); chk({tag, " R6 data"}, v, m_dat);
    rd(8'h0C, v); chk({tag, " R7 event"}, v, m_evt);
    rd(8'h10, v); chk({tag, " R2 mask"}, v, m_msk);
    rd(8'h14, v); chk({tag, " R2 ctl"}, v, m_ctl);
    chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, |(m_evt & m_msk)});
    chk({tag, " R4 pin_oe"}, pin_oe, rev(m_dir));
    chk({tag, " R4 pin_out"}, pin_out, rev(m_dat));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0069));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check_all("R1");

    // R2 register map and unknown offset
    wr(8'h04, 32'hA5A5_0F0F);
    wr(8'h10, 32'h0000_FFFF);
    wr(8'h14, 32'h00FF_00FF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, v); chk("R2 unknown offset reads zero", v, 32'h0);
    check_all("R2");

    // R3 non-word accesses
    wr(8'h10, 32'hFFFF_FFFF, 2'b00);
    wr(8'h10, 32'hFFFF_FFFF, 2'b01);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h10, v, 2'b01); chk("R3 halfword read zero", v, 32'h0);
    rd(8'h12, v);        chk("R3 misaligned read zero", v, 32'h0);
    check_all("R3");

    // R4/R5 outputs: pins 0 and 31 -> bits 31 and 0
    wr(8'h14, 32'h0);
    wr(8'h00, 32'h8000_0001);
    settle();
    wr(8'h08, 32'hFFFF_FFFF);
    settle();
    chk("R4 pin0 out", {31'd0, pin_out[0]}, 32'd1);
    chk("R4 pin0 oe", {31'd0, pin_oe[0]}, 32'd1);
    set_pins(32'h8000_0001);
    settle();
    chk("R5 output pins ignore input", pin_out & 32'h8000_0001, 32'h8000_0001);
    set_pins(32'h0);
    settle();
    check_all("R5");

    // R6/R11 latency: pin 5 (bit 26), any-change, masked
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0400_0000);
    settle();
    check_all("R6 pre");
    set_pins(32'h0000_0020);
    idle(1); chk("R6 irq low after k", {31'd0, irq}, 32'd0);
    idle(1); chk("R6 irq low after k+1", {31'd0, irq}, 32'd0);
    idle(1); chk("R6 irq high after k+2", {31'd0, irq}, 32'd1);
    settle();
    check_all("R6");

    // R8 falling-only on pin 7 (bit 24)
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0100_0000);
    set_pins(32'h0000_00A0);
    settle();
    rd(8'h0C, v); chk("R8 rise ignored", v & 32'h0100_0000, 32'h0);
    set_pins(32'h0000_0020);
    settle();
    rd(8'h0C, v); chk("R8 fall sets", v & 32'h0100_0000, 32'h0100_0000);
    check_all("R8");

    // R9 partial clear
    wr(8'h14, 32'h0);
    set_pins(32'h0F0F_0F0F);
    settle();
    wr(8'h0C, 32'h0F00_F000);
    rd(8'h0C, v); chk("R9 write-one-to-clear", v, m_evt);
    check_all("R9");

    // R10 set wins over same-edge clear (pin 12 -> bit 19)
    wr(8'h0C, 32'hFFFF_FFFF);
    settle();
    set_pins(pin_in ^ 32'h0000_1000);
    idle(2);
    wr(8'h0C, 32'h0008_0000);
    settle();
    rd(8'h0C, v); chk("R10 set wins", v & 32'h0008_0000, 32'h0008_0000);
    set_pins(pin_in ^ 32'h0000_1000);
    idle(3);
    model_inputs();
    wr(8'h0C, 32'h0008_0000);
    settle();
    rd(8'h0C, v); chk("R10 late clear wins", v & 32'h0008_0000, 32'h0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] r;
      op = int'($urandom_range(0, 6));
      r  = $urandom;
      case (op)
        0: wr(8'h00, r);
        1: wr(8'h14, r);
        2: wr(8'h10, r);
        3: set_pins(r);
        4: wr(8'h08, r);
        5: wr(8'h0C, r);
        default: wr(8'h04, r);
      endcase
      settle();
      check_all("RND");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule